// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block turns single-burst read and write requests, plus refresh, mode-load and low-power requests, into the command, bank and address pattern an SDRAM expects. It keeps a separate set of interval counters for every bank. While one bank is waiting out its row-to-column delay, a request for another bank can be activated, so activations and column commands from different banks interleave. Every idle cycle on the command output is a NOP.

Six minimum command spacings are read from two byte-wide set-up inputs. Each field holds the clock count minus one. Refresh recovery does not use any programmed field; it is a fixed parameter. Requests use a valid/ready handshake, and the ACTIVE for an accepted request is issued in the cycle after the handshake. The maintenance inputs are one-cycle pulses that the block holds internally until they are served.

The sequencer drives all of its outputs from registers. It runs the data bus, power-up initialisation and read-data capture only through the command stream it produces.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command output is NOP (code 0) and the clock-enable output is high.
- R2: Command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, MODE-SET=6, SELF-REFRESH-ENTRY=7. The ACTIVE for an accepted request appears one cycle after the handshake. It carries the request's bank, puts row bit 10 on the separate A10 output, and puts the remaining row bits in order (12,11,9..0) on the address output.
- R3: READ or WRITE for a bank comes at least tRCD clocks after its ACTIVE. It carries the bank and the column (zero-extended), with A10 low. The type matches the request.
- R4: PRECHARGE (A10 low, the bank on the bank output) comes at least tRAS clocks after the ACTIVE and at least BURST_LEN clocks after the READ or WRITE. It is issued in the first cycle where both limits are met and no other command needs that slot.
- R5: An ACTIVE to a bank comes at least tRC clocks after the previous ACTIVE to that bank and at least tRP clocks after its PRECHARGE.
- R6: An ACTIVE comes at least tRRD clocks after the previous ACTIVE to any bank. An ACTIVE to a different bank can be issued before the first bank's column command.
- R7: Field positions in register A are tRC=[2:0], tRP=[4:3], tRAS=[7:5]. In register B they are tRRD=[4:3], tRSC=[5], tRCD=[7:6]. Each field encodes its value plus one clocks. Bits [2:0] of register B have no effect.
- R8: REFRESH is issued only when every bank is closed and past its tRC and tRP. The next command comes exactly REF_GAP clocks later when it is ready, regardless of tRC.
- R9: MODE-SET puts the latched mode code on the address outputs using the row mapping. The next command comes at least tRSC clocks later.
- R10: SELF-REFRESH-ENTRY drives clock-enable low in the same cycle. Only NOP follows while it stays low. Clock-enable stays low for at least tRAS clocks and rises after an exit request. The next ACTIVE comes at least tRC clocks after the rise.
- R11: Each accepted request produces exactly one ACTIVE, one READ or WRITE and one PRECHARGE, and each maintenance pulse produces exactly one matching command.
- R12: While a refresh, mode-set or self-refresh entry is pending, no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tcfg_a | input | 8 | Timing set-up register A (tRC, tRP, tRAS) |
| tcfg_b | input | 8 | Timing set-up register B (tRRD, tRSC, tRCD) |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Row address |
| req_col | input | 10 | Column address |
| ref_req | input | 1 | Pulse: perform one auto-refresh |
| mrs_req | input | 1 | Pulse: load mode register |
| mrs_code | input | 13 | Mode value, latched with mrs_req |
| sr_enter | input | 1 | Pulse: enter self-refresh |
| sr_exit | input | 1 | Pulse: leave self-refresh |
| sd_cmd | output | 3 | Encoded command |
| sd_ba | output | 2 | Bank address |
| sd_adr | output | 12 | Address bits 12, 11, 9..0 |
| sd_a10 | output | 1 | Address bit 10 |
| sd_cke | output | 1 | Clock enable |

## Verification
The bench builds the block with its defaults: four banks, a 13-bit row, a 10-bit column, a burst of four and a four-clock refresh recovery. With four banks, up to three other banks can be activated while one waits for its column command. This exercises the tRRD spacing and the lowest-bank ordering of pending column and precharge commands. A burst of four combined with tRAS from one to eight lets either the burst or tRAS be the limit on PRECHARGE. The four-clock recovery is shorter than the maximum tRC, so a directed case shows that refresh recovery ignores tRC.

// File: rtl/sdseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the SDRAM command sequencer.
// Assumes: codes are consumed by a pad decoder outside this block.
package sdseq_pkg;

    // Encoded command issued on the command output.
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_MRS  = 3'd6,
        CMD_SREF = 3'd7
    } sd_cmd_e;

    // Decoded intervals, each stored as clocks minus one.
    typedef struct packed {
        logic [2:0] rc;
        logic [2:0] ras;
        logic [1:0] rp;
        logic [1:0] rcd;
        logic [1:0] rrd;
        logic       rsc;
    } sd_timing_t;

endpackage

// File: rtl/sdseq_cfg_decode.sv
`timescale 1ns/1ps
// Splits the two set-up bytes into interval fields.
// Assumes: fields already hold "clocks minus one", so no arithmetic is needed.
module sdseq_cfg_decode
    import sdseq_pkg::*;
(
    input  logic [7:0]  cfg_a,
    input  logic [4:0]  cfg_b_hi,   // bits [7:3] of register B
    output sd_timing_t  tim
);
    // Field extraction for register A and the upper part of register B.
    always_comb begin
        tim.rc  = cfg_a[2:0];
        tim.rp  = cfg_a[4:3];
        tim.ras = cfg_a[7:5];
        tim.rrd = cfg_b_hi[1:0];
        tim.rsc = cfg_b_hi[2];
        tim.rcd = cfg_b_hi[4:3];
    end
endmodule

// File: rtl/sdseq_bank_timer.sv
`timescale 1ns/1ps
// Per-bank state and interval counters.
// Tracks whether the row is open, whether a column command is still owed,
// and counts down tRC, tRAS, tRCD, tRP and the burst occupancy.
// Assumes: the arbiter fires at most one command to this bank per cycle and
// fires only when the matching can_* output is high.
module sdseq_bank_timer
    import sdseq_pkg::*;
#(
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sd_timing_t       tim,
    input  logic             act_fire,
    input  logic             rw_fire,
    input  logic             pre_fire,
    input  logic             acc_wr,
    input  logic [COL_W-1:0] acc_col,
    output logic             is_open,
    output logic             pend_wr,
    output logic [COL_W-1:0] pend_col,
    output logic             can_act,
    output logic             can_rw,
    output logic             can_pre
);
    localparam int             BL_W    = $clog2(BURST_LEN + 1);
    localparam logic [BL_W-1:0] BL_LOAD = BL_W'(BURST_LEN - 1);

    logic            open_q, pend_q, wr_q;
    logic [COL_W-1:0] col_q;
    logic [2:0]      rc_cnt, ras_cnt;
    logic [1:0]      rcd_cnt, rp_cnt;
    logic [BL_W-1:0] bl_cnt;

    // Row state and the column command owed for the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            pend_q <= 1'b0;
            wr_q   <= 1'b0;
            col_q  <= '0;
        end else begin
            if (act_fire) begin
                open_q <= 1'b1;
                pend_q <= 1'b1;
                wr_q   <= acc_wr;
                col_q  <= acc_col;
            end
            if (rw_fire)  pend_q <= 1'b0;
            if (pre_fire) open_q <= 1'b0;
        end
    end

    // Interval counters: load on the starting command, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_cnt  <= '0;
            ras_cnt <= '0;
            rcd_cnt <= '0;
            rp_cnt  <= '0;
            bl_cnt  <= '0;
        end else begin
            if (act_fire)            rc_cnt <= tim.rc;
            else if (rc_cnt != 3'd0) rc_cnt <= rc_cnt - 3'd1;

            if (act_fire)             ras_cnt <= tim.ras;
            else if (ras_cnt != 3'd0) ras_cnt <= ras_cnt - 3'd1;

            if (act_fire)             rcd_cnt <= tim.rcd;
            else if (rcd_cnt != 2'd0) rcd_cnt <= rcd_cnt - 2'd1;

            if (pre_fire)            rp_cnt <= tim.rp;
            else if (rp_cnt != 2'd0) rp_cnt <= rp_cnt - 2'd1;

            if (rw_fire)            bl_cnt <= BL_LOAD;
            else if (bl_cnt != '0)  bl_cnt <= bl_cnt - 1'b1;
        end
    end

    // Eligibility flags offered to the arbiter.
    always_comb begin
        can_act = !open_q && (rc_cnt == 3'd0) && (rp_cnt == 2'd0);
        can_rw  = pend_q && (rcd_cnt == 2'd0);
        can_pre = open_q && !pend_q && (ras_cnt == 3'd0) && (bl_cnt == '0);
    end

    assign is_open  = open_q;
    assign pend_wr  = wr_q;
    assign pend_col = col_q;

    // An ACTIVE never lands on an already open row.
    assert_act_on_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> !open_q);
    // With tRCD above one clock the column command cannot follow ACTIVE directly.
    assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fire && tim.rcd != 2'd0) |=> !rw_fire);
    // Burst occupancy blocks PRECHARGE right after a column command.
    assert_burst_before_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_fire && BURST_LEN > 1) |=> !pre_fire);
    // With tRP above one clock the bank cannot reopen right after PRECHARGE.
    assert_rp_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire && tim.rp != 2'd0) |=> !act_fire);
endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
// SDRAM command timing sequencer (top).
// Accepts single-burst requests and maintenance pulses, and arbitrates one
// command per cycle in the order PRECHARGE > column > maintenance > ACTIVE.
// All pin outputs are registered. Assumes BANKS is a power of two and
// ROW_W >= 12 so that row bit 10 exists.
module sdram_cmd_seq
    import sdseq_pkg::*;
#(
    parameter int BANKS     = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 4,
    parameter int REF_GAP   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               tcfg_a,
    input  logic [7:0]               tcfg_b,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [$clog2(BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [COL_W-1:0]         req_col,
    input  logic                     ref_req,
    input  logic                     mrs_req,
    input  logic [ROW_W-1:0]         mrs_code,
    input  logic                     sr_enter,
    input  logic                     sr_exit,
    output logic [2:0]               sd_cmd,
    output logic [$clog2(BANKS)-1:0] sd_ba,
    output logic [ROW_W-2:0]         sd_adr,
    output logic                     sd_a10,
    output logic                     sd_cke
);
    localparam int BA_W    = $clog2(BANKS);
    localparam int ADR_W   = ROW_W - 1;
    localparam int GAP_MAX = (REF_GAP - 1 > 7) ? REF_GAP - 1 : 7;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    sd_timing_t tim;
    logic       cfg_b_unused;

    // Row/mode code to pins: bit 10 goes to A10, the rest packed in order.
    function automatic logic [ADR_W-1:0] row_pins(input logic [ROW_W-1:0] r);
        return {r[ROW_W-1:11], r[9:0]};
    endfunction

    sdseq_cfg_decode u_decode (
        .cfg_a    (tcfg_a),
        .cfg_b_hi (tcfg_b[7:3]),
        .tim      (tim)
    );
    assign cfg_b_unused = ^tcfg_b[2:0];

    // Per-bank status
    logic [BANKS-1:0] bk_open, bk_wr, bk_can_act, bk_can_rw, bk_can_pre;
    logic [COL_W-1:0] bk_col [BANKS];

    // Arbitration results
    logic            free, all_idle, maint_hold, maint_ok;
    logic            pre_go, rw_go, act_go, ref_go, mrs_go, sref_go, srx_go;
    logic [BA_W-1:0] pre_sel, rw_sel;

    // Maintenance and global timers
    logic             ref_pend, mrs_pend, sre_pend, srx_pend, in_sr;
    logic [ROW_W-1:0] mrs_q;
    logic [1:0]       rrd_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic [2:0]       sr_cnt;

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        sdseq_bank_timer #(
            .COL_W     (COL_W),
            .BURST_LEN (BURST_LEN)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .tim      (tim),
            .act_fire (act_go && (req_bank == BA_W'(g))),
            .rw_fire  (rw_go && (rw_sel == BA_W'(g))),
            .pre_fire (pre_go && (pre_sel == BA_W'(g))),
            .acc_wr   (req_write),
            .acc_col  (req_col),
            .is_open  (bk_open[g]),
            .pend_wr  (bk_wr[g]),
            .pend_col (bk_col[g]),
            .can_act  (bk_can_act[g]),
            .can_rw   (bk_can_rw[g]),
            .can_pre  (bk_can_pre[g])
        );
    end

    // Lowest-numbered eligible bank for PRECHARGE and for the column command.
    always_comb begin
        pre_sel = '0;
        rw_sel  = '0;
        for (int b = BANKS - 1; b >= 0; b--) begin
            if (bk_can_pre[b]) pre_sel = BA_W'(b);
            if (bk_can_rw[b])  rw_sel  = BA_W'(b);
        end
    end

    // One-command-per-cycle priority arbitration.
    always_comb begin
        free       = !in_sr && (gap_cnt == '0);
        all_idle   = (&bk_can_act) && !(|bk_can_rw) && !(|bk_open);
        maint_hold = ref_pend || mrs_pend || sre_pend;
        pre_go     = free && (|bk_can_pre);
        rw_go      = free && !pre_go && (|bk_can_rw);
        maint_ok   = free && !pre_go && !rw_go && all_idle;
        ref_go     = maint_ok && ref_pend;
        mrs_go     = maint_ok && !ref_pend && mrs_pend;
        sref_go    = maint_ok && !ref_pend && !mrs_pend && sre_pend;
        req_ready  = free && !pre_go && !rw_go && !maint_hold
                     && bk_can_act[req_bank] && (rrd_cnt == 2'd0);
        act_go     = req_valid && req_ready;
        srx_go     = in_sr && (sr_cnt == 3'd0) && srx_pend;
    end

    // Latch maintenance pulses until served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pend <= 1'b0;
            mrs_pend <= 1'b0;
            sre_pend <= 1'b0;
            srx_pend <= 1'b0;
            mrs_q    <= '0;
        end else begin
            ref_pend <= (ref_pend && !ref_go) || ref_req;
            mrs_pend <= (mrs_pend && !mrs_go) || mrs_req;
            sre_pend <= (sre_pend && !sref_go) || sr_enter;
            srx_pend <= (srx_pend && !srx_go) || (sr_exit && in_sr);
            if (mrs_req) mrs_q <= mrs_code;
        end
    end

    // Global spacing: bank-to-bank activate, recovery after maintenance, self-refresh residency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_cnt <= '0;
            gap_cnt <= '0;
            sr_cnt  <= '0;
            in_sr   <= 1'b0;
        end else begin
            if (act_go)               rrd_cnt <= tim.rrd;
            else if (rrd_cnt != 2'd0) rrd_cnt <= rrd_cnt - 2'd1;

            if (ref_go)              gap_cnt <= GAP_W'(REF_GAP - 1);
            else if (mrs_go)         gap_cnt <= GAP_W'(tim.rsc);
            else if (srx_go)         gap_cnt <= GAP_W'(tim.rc);
            else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;

            if (sref_go)                    sr_cnt <= tim.ras;
            else if (in_sr && sr_cnt != 0)  sr_cnt <= sr_cnt - 3'd1;

            if (sref_go)     in_sr <= 1'b1;
            else if (srx_go) in_sr <= 1'b0;
        end
    end

    // Registered pin drive for the chosen command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_cmd <= CMD_NOP;
            sd_ba  <= '0;
            sd_adr <= '0;
            sd_a10 <= 1'b0;
            sd_cke <= 1'b1;
        end else begin
            sd_cmd <= CMD_NOP;
            sd_ba  <= '0;
            sd_adr <= '0;
            sd_a10 <= 1'b0;
            if (pre_go) begin
                sd_cmd <= CMD_PRE;
                sd_ba  <= pre_sel;
            end else if (rw_go) begin
                sd_cmd <= bk_wr[rw_sel] ? CMD_WR : CMD_RD;
                sd_ba  <= rw_sel;
                sd_adr <= ADR_W'(bk_col[rw_sel]);
            end else if (ref_go) begin
                sd_cmd <= CMD_REF;
            end else if (mrs_go) begin
                sd_cmd <= CMD_MRS;
                sd_adr <= row_pins(mrs_q);
                sd_a10 <= mrs_q[10];
            end else if (sref_go) begin
                sd_cmd <= CMD_SREF;
            end else if (act_go) begin
                sd_cmd <= CMD_ACT;
                sd_ba  <= req_bank;
                sd_adr <= row_pins(req_row);
                sd_a10 <= req_row[10];
            end
            if (sref_go)     sd_cke <= 1'b0;
            else if (srx_go) sd_cke <= 1'b1;
        end
    end

    // Only one command source wins per cycle.
    assert_one_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_go, rw_go, ref_go, mrs_go, sref_go, act_go}));
    // Maintenance commands need every row closed.
    assert_maint_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_go || mrs_go || sref_go) |-> !(|bk_open));
    // REFRESH recovery keeps the following cycle quiet.
    assert_ref_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_REF && REF_GAP > 1) |=> (sd_cmd == CMD_NOP));
    // While clock-enable stays low, only NOP is driven.
    assert_sr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && !$fell(sd_cke)) |-> (sd_cmd == CMD_NOP));
    // Bank-to-bank activates respect tRRD when it exceeds one clock.
    assert_rrd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_go && tim.rrd != 2'd0) |=> !act_go);
    // Pending maintenance blocks new requests.
    assert_maint_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend || mrs_pend || sre_pend) |-> !req_ready);
endmodule

// File: tb/sdram_cmd_seq_bench.sv
`timescale 1ns/1ps
module sdram_cmd_seq_bench;
    localparam int BL = 4;
    localparam int RG = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  tcfg_a = 8'h00, tcfg_b = 8'h00;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0, mrs_code = '0;
    logic [9:0]  req_col = '0;
    logic        ref_req = 1'b0, mrs_req = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
    logic        req_ready, sd_a10, sd_cke;
    logic [2:0]  sd_cmd;
    logic [1:0]  sd_ba;
    logic [11:0] sd_adr;

    sdram_cmd_seq u_sdram_cmd_seq (
        .clk(clk), .rst_n(rst_n), .tcfg_a(tcfg_a), .tcfg_b(tcfg_b),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .ref_req(ref_req), .mrs_req(mrs_req), .mrs_code(mrs_code),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .sd_cmd(sd_cmd), .sd_ba(sd_ba),
        .sd_adr(sd_adr), .sd_a10(sd_a10), .sd_cke(sd_cke)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    integer total = 0, bad = 0, cyc = 0, wd = 0;
    integer t_act[4], t_pre[4], t_rw[4];
    integer t_act_any = -100, t_ref = -100, t_mrs = -100, t_sre = -100, t_srx = -100;
    bit     open_m[4], rw_done[4];
    bit     pend_wr_m[4];
    logic [9:0]  pend_col_m[4];
    logic [12:0] pend_row_m[4];
    bit     exp_act = 0, cke_prev = 1;
    logic [1:0] exp_bank = '0;
    integer n_acc = 0, n_act = 0, n_rw = 0, n_pre = 0, n_ref = 0, n_mrs = 0, n_sre = 0;
    integer n_ref_req = 0, n_mrs_req = 0, n_sre_req = 0;

    // Interval values (clocks) from the set-up bytes.
    function automatic integer f_rc();  return tcfg_a[2:0] + 1; endfunction
    function automatic integer f_rp();  return tcfg_a[4:3] + 1; endfunction
    function automatic integer f_ras(); return tcfg_a[7:5] + 1; endfunction
    function automatic integer f_rrd(); return tcfg_b[4:3] + 1; endfunction
    function automatic integer f_rsc(); return tcfg_b[5] + 1;   endfunction
    function automatic integer f_rcd(); return tcfg_b[7:6] + 1; endfunction
    function automatic logic [11:0] pins(input logic [12:0] r);
        return {r[12:11], r[9:0]};
    endfunction

    task automatic chk(input bit ok, input string rq, input integer act, input integer expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", rq, cyc, act, expv);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Command monitor: per-bank timestamp model.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cke_prev && !sd_cke) begin
                chk(sd_cmd == 3'd7, "R10 entry code", sd_cmd, 7);
                t_sre = cyc; n_sre++;
            end else if (!cke_prev && sd_cke) begin
                chk(cyc - t_sre >= f_ras(), "R10 residency", cyc - t_sre, f_ras());
                t_srx = cyc;
            end else if (!sd_cke) begin
                chk(sd_cmd == 3'd0, "R10 quiet", sd_cmd, 0);
            end
            cke_prev = sd_cke;
            if (sd_cmd != 3'd0) begin
                chk(cyc - t_ref >= RG, "R8 recovery", cyc - t_ref, RG);
                chk(cyc - t_mrs >= f_rsc(), "R9 spacing", cyc - t_mrs, f_rsc());
                chk(cyc - t_srx >= 1, "R10 exit", cyc - t_srx, 1);
            end
            if (exp_act) chk(sd_cmd == 3'd1 && sd_ba == exp_bank, "R2 act follows accept", sd_cmd, 1);
            case (sd_cmd)
                3'd1: begin
                    n_act++;
                    chk(exp_act, "R11 unrequested act", 0, 1);
                    chk(sd_adr == pins(pend_row_m[sd_ba]), "R2 row pins", sd_adr, pins(pend_row_m[sd_ba]));
                    chk(sd_a10 == pend_row_m[sd_ba][10], "R2 a10", sd_a10, pend_row_m[sd_ba][10]);
                    chk(cyc - t_act[sd_ba] >= f_rc(), "R5 tRC", cyc - t_act[sd_ba], f_rc());
                    chk(cyc - t_pre[sd_ba] >= f_rp(), "R5 tRP", cyc - t_pre[sd_ba], f_rp());
                    chk(cyc - t_act_any >= f_rrd(), "R6 tRRD", cyc - t_act_any, f_rrd());
                    chk(cyc - t_srx >= f_rc(), "R10 exit to act", cyc - t_srx, f_rc());
                    chk(!open_m[sd_ba], "R5 closed", open_m[sd_ba], 0);
                    open_m[sd_ba] = 1; rw_done[sd_ba] = 0;
                    t_act[sd_ba] = cyc; t_act_any = cyc;
                end
                3'd2, 3'd3: begin
                    n_rw++;
                    chk(open_m[sd_ba] && !rw_done[sd_ba], "R11 column owed", rw_done[sd_ba], 0);
                    chk(cyc - t_act[sd_ba] >= f_rcd(), "R3 tRCD", cyc - t_act[sd_ba], f_rcd());
                    chk(sd_adr == {2'b00, pend_col_m[sd_ba]} && !sd_a10, "R3 column pins", sd_adr, pend_col_m[sd_ba]);
                    chk((sd_cmd == 3'd3) == pend_wr_m[sd_ba], "R3 type", sd_cmd, pend_wr_m[sd_ba] ? 3 : 2);
                    rw_done[sd_ba] = 1; t_rw[sd_ba] = cyc;
                end
                3'd4: begin
                    n_pre++;
                    chk(open_m[sd_ba] && rw_done[sd_ba], "R4 pre after column", rw_done[sd_ba], 1);
                    chk(cyc - t_act[sd_ba] >= f_ras(), "R4 tRAS", cyc - t_act[sd_ba], f_ras());
                    chk(cyc - t_rw[sd_ba] >= BL, "R4 burst", cyc - t_rw[sd_ba], BL);
                    chk(!sd_a10, "R4 a10 low", sd_a10, 0);
                    open_m[sd_ba] = 0; t_pre[sd_ba] = cyc;
                end
                3'd5, 3'd6, 3'd7: begin
                    for (int b = 0; b < 4; b++) begin
                        chk(!open_m[b], "R8 banks closed", open_m[b], 0);
                        chk(cyc - t_pre[b] >= f_rp() && cyc - t_act[b] >= f_rc(), "R8 bank settled", cyc - t_act[b], f_rc());
                    end
                    if (sd_cmd == 3'd5) begin t_ref = cyc; n_ref++; end
                    if (sd_cmd == 3'd6) begin
                        chk(sd_adr == pins(mrs_code) && sd_a10 == mrs_code[10], "R9 mode pins", sd_adr, pins(mrs_code));
                        t_mrs = cyc; n_mrs++;
                    end
                end
                default: ;
            endcase
            exp_act = req_valid && req_ready;
            if (exp_act) begin
                n_acc++;
                exp_bank = req_bank;
                pend_row_m[req_bank] = req_row;
                pend_col_m[req_bank] = req_col;
                pend_wr_m[req_bank]  = req_write;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            chk(0, "watchdog", wd, 150000);
            summary();
            $finish;
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic drain(input integer n); repeat (n) tick(); endtask

    task automatic send(input logic [1:0] b, input logic [12:0] r, input logic [9:0] c, input bit w);
        req_valid = 1; req_bank = b; req_row = r; req_col = c; req_write = w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic do_ref(); ref_req = 1; n_ref_req++; tick(); ref_req = 0; endtask
    task automatic do_mrs(); mrs_req = 1; n_mrs_req++; tick(); mrs_req = 0; endtask

    task automatic counts(input string tag);
        chk(n_act == n_acc && n_rw == n_acc && n_pre == n_acc, "R11 one of each per request", n_pre, n_acc);
        chk(n_ref == n_ref_req, "R11 refresh count", n_ref, n_ref_req);
        chk(n_mrs == n_mrs_req && n_sre == n_sre_req, "R11 maint count", n_mrs, n_mrs_req);
        if (bad != 0) $display("note: failures seen by %s", tag);
    endtask

    initial begin
        for (int b = 0; b < 4; b++) begin
            t_act[b] = -100; t_pre[b] = -100; t_rw[b] = -100;
            open_m[b] = 0; rw_done[b] = 0;
        end
        void'($urandom(32'd20240611));
        drain(3);
        rst_n = 1;
        @(negedge clk);
        chk(sd_cmd == 3'd0, "R1 reset cmd", sd_cmd, 0);
        chk(sd_cke == 1'b1, "R1 reset cke", sd_cke, 1);
        tick();

        // R3 R4 R7: tRAS=6, tRP=2, tRC=8, tRCD=3, tRRD=3; low bits of B set to show no effect
        tcfg_a = {3'd5, 2'd1, 3'd7};
        tcfg_b = {2'd2, 1'b0, 2'd2, 3'b111};
        send(2'd1, 13'h1555, 10'h02A, 1'b0);
        drain(20);
        chk(t_rw[1] - t_act[1] == 3, "R3 R7 exact tRCD", t_rw[1] - t_act[1], 3);
        chk(t_pre[1] - t_act[1] == 7, "R4 exact pre (burst bound)", t_pre[1] - t_act[1], 7);

        // R4: tRAS bound dominates (tRAS=8, tRCD=1)
        tcfg_a = {3'd7, 2'd0, 3'd7};
        tcfg_b = {2'd0, 1'b0, 2'd0, 3'b000};
        send(2'd2, 13'h0ABC, 10'h3FF, 1'b1);
        drain(20);
        chk(t_pre[2] - t_act[2] == 8, "R4 exact pre (tRAS bound)", t_pre[2] - t_act[2], 8);

        // R6: interleave with tRCD=4, tRRD=3
        tcfg_b = {2'd3, 1'b0, 2'd2, 3'b000};
        send(2'd0, 13'h0400, 10'h011, 1'b0);
        send(2'd2, 13'h1BFF, 10'h022, 1'b0);
        drain(25);
        chk(t_act[2] - t_act[0] == 3, "R6 interleaved act", t_act[2] - t_act[0], 3);
        chk(t_act[2] < t_rw[0], "R6 act before column", t_act[2], t_rw[0]);

        // R8 R12: refresh ignores tRC=8, request waits
        do_ref();
        send(2'd3, 13'h0001, 10'h005, 1'b1);
        drain(25);
        chk(t_act[3] - t_ref == RG, "R8 R12 refresh recovery", t_act[3] - t_ref, RG);

        // R9: mode set with tRSC=2
        tcfg_b = {2'd0, 1'b1, 2'd0, 3'b000};
        mrs_code = 13'h0432;
        do_mrs();
        send(2'd1, 13'h0777, 10'h100, 1'b0);
        drain(25);
        chk(t_act[1] - t_mrs == 2, "R9 mode recovery", t_act[1] - t_mrs, 2);

        // R10: self-refresh with tRAS=5, tRC=7
        tcfg_a = {3'd4, 2'd0, 3'd6};
        sr_enter = 1; n_sre_req++; tick(); sr_enter = 0;
        drain(3);
        chk(sd_cke == 1'b0, "R10 cke low", sd_cke, 0);
        sr_exit = 1; tick(); sr_exit = 0;
        send(2'd0, 13'h1234, 10'h0F0, 1'b1);
        drain(25);
        chk(t_act[0] - t_srx == 7, "R10 exit to act", t_act[0] - t_srx, 7);
        counts("directed");

        // Random phases
        for (int k = 0; k < 6; k++) begin
            tcfg_a = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
            tcfg_b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
            mrs_code = 13'($urandom);
            for (int i = 0; i < 50; i++) begin
                if (i % 17 == 5) begin
                    while (n_ref != n_ref_req) @(negedge clk);
                    #0; @(posedge clk); #1;
                    do_ref();
                end
                if (i % 23 == 11) begin
                    while (n_mrs != n_mrs_req) @(negedge clk);
                    @(posedge clk); #1;
                    do_mrs();
                end
                if (k == 3 && i == 25) begin
                    sr_enter = 1; n_sre_req++; tick(); sr_enter = 0;
                    drain(12);
                    sr_exit = 1; tick(); sr_exit = 0;
                end
                send(2'($urandom), 13'($urandom), 10'($urandom), 1'($urandom));
                if ($urandom % 4 == 0) drain($urandom % 6);
            end
            drain(60);
            counts("random");
        end

        summary();
        $finish;
    end
endmodule